// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block sits between a host register bus and the pins of a NAND flash device. Software loads a command byte or an address byte into a register and then writes one bit of an operation register to send it. The block then generates the latch-enable strobe, the write-enable pulse and the data byte with a fixed timing for each phase. Page program, page read, ID read and status read are passed to an external buffer engine as a one-cycle request that carries the transfer kind and the buffer number. For program, page read and status, the block waits for the device's ready/busy line to fall and then rise before it reports completion. A watchdog ends a wait that never finishes and flags it as an error.

Software polls bit 15 of the operation register to see completion, and never reads ready/busy directly. A multi-byte address is sent as a series of single-byte address operations. For a large page this is the column low byte, then the column high byte, then the row bytes with the least significant first. The configuration register holds the chip-enable bit and a reset bit that clears itself. Buffer number and active chip are set in a separate register.

Top module: `nand_op_seq`

## Requirements
- R1: After rst_ni is released, every register reads zero, we_no is 1, cle_o and ale_o are 0, all ce_no bits are 1 and xfer_req_o is 0. Register word addresses: 0 buffer/chip, 1 address, 2 command, 3 configuration, 4 operation.
- R2: Writing operation bit 0 runs a command cycle. cle_o is high for SETUP_CYC+PULSE_CYC+HOLD_CYC cycles with ale_o low. we_no is low for PULSE_CYC cycles, starting SETUP_CYC cycles after the start. The low byte of the command register is driven on dq_o, with dq_oe_o high.
- R3: Writing operation bit 1 runs an address cycle with the same timing, with ale_o in place of cle_o. Only the low byte of the address register is sent.
- R4: Operation bit 15 reads 0 from the cycle after a starting write and reads 1 once the operation is finished. For a command or address cycle this is SETUP_CYC+PULSE_CYC+HOLD_CYC cycles after the start. The byte sent is the one held when the operation started.
- R5: Operation bits 2, 3, 4 and 5 (program, read page, read ID, read status) each produce exactly one single-cycle xfer_req_o. It carries xfer_kind_o = 0, 1, 2 or 3 respectively and buf_sel_o = buffer register bits 2:0. A read ID completes in the cycle after the request.
- R6: Program, read page and read status complete only after the synchronised ready/busy input has been seen low and then high again. In that case bit 14 (error) reads 0.
- R7: If the ready/busy wait lasts WDOG_CYC cycles, the operation completes with bit 14 set. The next accepted start clears bit 14.
- R8: Operation writes are ignored while an operation is running, and also when bits 5:0 are not exactly one-hot. In either case no cycle or request starts, and the operation register keeps its value.
- R9: When configuration bit 7 is 1, ce_no[k] is 0 only for k equal to buffer register bits 6:5. When configuration bit 7 is 0, all ce_no bits are 1.
- R10: Writing configuration bit 6 makes that bit read 1 for RST_CYC cycles and then 0. During that time a running operation is aborted, the strobes go idle, and the operation register, including done and error, is cleared. Configuration bit 7 keeps the written value.
- R11: A large-page read, sent as command 0x00, five address bytes, command 0x30 and then a read-page operation, reaches the pins in that order and ends with one read-page request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address (write and read) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| rb_ni | input | 1 | Flash ready/busy, low while busy |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write enable, active low |
| dq_o | output | 8 | Flash data bus out |
| dq_oe_o | output | 1 | Data bus drive enable |
| ce_no | output | NUM_CE | Chip enables, active low |
| xfer_req_o | output | 1 | One-cycle request to the buffer engine |
| xfer_kind_o | output | 2 | Request kind: 0 program, 1 read page, 2 ID, 3 status |
| buf_sel_o | output | 3 | Buffer number for the request |

## Verification
The bench builds the block with SETUP_CYC=2, PULSE_CYC=3, HOLD_CYC=1, WDOG_CYC=24 and RST_CYC=4. With these values every phase length can be counted by hand, and a watchdog expiry comes within a few dozen cycles. The short timings make it cheap to sweep all 256 command bytes and all 256 address bytes. The bench also covers every transfer kind with every buffer number, every chip with enable on and off, and a grid of busy delays and busy lengths. Stuck-busy and never-busy devices, a reset that aborts an operation, and a full large-page read sequence are each covered by a directed case.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD, ST_XFER, ST_WLO, ST_WHI
  } seq_state_e;

  typedef enum logic [1:0] {
    XK_PROG = 2'd0, XK_READ = 2'd1, XK_ID = 2'd2, XK_STAT = 2'd3
  } xfer_kind_e;

  localparam int unsigned OP_BITS  = 6;
  localparam logic [2:0]  RA_BUF   = 3'd0;
  localparam logic [2:0]  RA_ADDR  = 3'd1;
  localparam logic [2:0]  RA_CMD   = 3'd2;
  localparam logic [2:0]  RA_CTRL  = 3'd3;
  localparam logic [2:0]  RA_OP    = 3'd4;
  localparam int unsigned CS_LSB   = 5;
  localparam int unsigned RST_BIT  = 6;
  localparam int unsigned CE_BIT   = 7;
  localparam int unsigned ERR_BIT  = 14;
  localparam int unsigned DONE_BIT = 15;
endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int unsigned RST_CYC = 8,
  parameter int unsigned CS_W    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [2:0]         addr_i,
  input  logic [15:0]        wdata_i,
  output logic [15:0]        rdata_o,
  input  logic               busy_i,
  input  logic               fin_i,
  input  logic               fin_err_i,
  output logic               start_o,
  output logic [OP_BITS-1:0] op_o,
  output logic               abort_o,
  output logic [7:0]         cmd_o,
  output logic [7:0]         addr_byte_o,
  output logic [2:0]         buf_o,
  output logic [CS_W-1:0]    cs_o,
  output logic               ce_en_o
);
  localparam int unsigned RC_W = $clog2(RST_CYC + 1);

  logic [RC_W-1:0]    rst_cnt_q;
  logic [OP_BITS-1:0] op_q;
  logic               done_q, err_q;
  logic               op_wr, ctrl_wr;
  logic [7:0]         unused_wdata;

  assign op_wr        = wr_i && (addr_i == RA_OP);
  assign ctrl_wr      = wr_i && (addr_i == RA_CTRL);
  assign abort_o      = (rst_cnt_q != '0);
  assign start_o      = op_wr && $onehot(wdata_i[OP_BITS-1:0]) && !busy_i && !abort_o;
  assign op_o         = wdata_i[OP_BITS-1:0];
  assign unused_wdata = wdata_i[15:8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o       <= '0;
      cs_o        <= '0;
      addr_byte_o <= '0;
      cmd_o       <= '0;
      ce_en_o     <= 1'b0;
      rst_cnt_q   <= '0;
      op_q        <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          RA_BUF: begin
            buf_o <= wdata_i[2:0];
            cs_o  <= wdata_i[CS_LSB +: CS_W];
          end
          RA_ADDR: addr_byte_o <= wdata_i[7:0];
          RA_CMD:  cmd_o       <= wdata_i[7:0];
          RA_CTRL: ce_en_o     <= wdata_i[CE_BIT];
          default: ;
        endcase
      end
      if (ctrl_wr && wdata_i[RST_BIT]) rst_cnt_q <= RC_W'(RST_CYC);
      else if (abort_o)                rst_cnt_q <= rst_cnt_q - 1'b1;
      if (abort_o) begin
        op_q   <= '0;
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (start_o) begin
        op_q   <= wdata_i[OP_BITS-1:0];
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (fin_i) begin
        done_q <= 1'b1;
        err_q  <= fin_err_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_BUF: begin
        rdata_o[2:0]               = buf_o;
        rdata_o[CS_LSB +: CS_W]    = cs_o;
      end
      RA_ADDR: rdata_o[7:0] = addr_byte_o;
      RA_CMD:  rdata_o[7:0] = cmd_o;
      RA_CTRL: begin
        rdata_o[CE_BIT]  = ce_en_o;
        rdata_o[RST_BIT] = abort_o;
      end
      RA_OP: begin
        rdata_o[OP_BITS-1:0] = op_q;
        rdata_o[ERR_BIT]     = err_q;
        rdata_o[DONE_BIT]    = done_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned WDOG_CYC  = 4096
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [OP_BITS-1:0] op_i,
  input  logic               abort_i,
  input  logic [7:0]         cmd_i,
  input  logic [7:0]         addr_i,
  input  logic               rb_ni,
  output logic               busy_o,
  output logic               fin_o,
  output logic               fin_err_o,
  output logic               cle_o,
  output logic               ale_o,
  output logic               we_no,
  output logic [7:0]         dq_o,
  output logic               dq_oe_o,
  output logic               xfer_req_o,
  output logic [1:0]         xfer_kind_o
);
  localparam int unsigned PH_MAX = (SETUP_CYC > PULSE_CYC)
                                   ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                                   : ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int unsigned CNT_W  = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
  localparam int unsigned WD_W   = $clog2(WDOG_CYC + 1);

  seq_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, ph_last;
  logic [WD_W-1:0]  wd_q, wd_d;
  logic             is_addr_q;
  logic [7:0]       byte_q;
  xfer_kind_e       kind_q, kind_d;
  logic [1:0]       rb_sync_q;
  logic             rb_ready, strobe, wd_out;

  assign rb_ready = rb_sync_q[1];
  assign wd_out   = (wd_q == WD_W'(WDOG_CYC - 1));

  always_comb begin
    case (state_q)
      ST_SETUP: ph_last = CNT_W'(SETUP_CYC - 1);
      ST_PULSE: ph_last = CNT_W'(PULSE_CYC - 1);
      default:  ph_last = CNT_W'(HOLD_CYC - 1);
    endcase
  end

  always_comb begin
    if (op_i[2])      kind_d = XK_PROG;
    else if (op_i[3]) kind_d = XK_READ;
    else if (op_i[4]) kind_d = XK_ID;
    else              kind_d = XK_STAT;
  end

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    wd_d      = wd_q;
    fin_o     = 1'b0;
    fin_err_o = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        cnt_d   = '0;
        state_d = (op_i[0] || op_i[1]) ? ST_SETUP : ST_XFER;
      end
      ST_SETUP, ST_PULSE, ST_HOLD: begin
        if (cnt_q == ph_last) begin
          cnt_d = '0;
          case (state_q)
            ST_SETUP: state_d = ST_PULSE;
            ST_PULSE: state_d = ST_HOLD;
            default: begin
              state_d = ST_IDLE;
              fin_o   = 1'b1;
            end
          endcase
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_XFER: begin
        wd_d = '0;
        if (kind_q == XK_ID) begin
          state_d = ST_IDLE;
          fin_o   = 1'b1;
        end else begin
          state_d = ST_WLO;
        end
      end
      ST_WLO, ST_WHI: begin
        if (state_q == ST_WHI && rb_ready) begin
          state_d = ST_IDLE;
          fin_o   = 1'b1;
        end else if (wd_out) begin
          state_d   = ST_IDLE;
          fin_o     = 1'b1;
          fin_err_o = 1'b1;
        end else begin
          wd_d = wd_q + 1'b1;
          if (state_q == ST_WLO && !rb_ready) state_d = ST_WHI;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort_i) begin
      state_d   = ST_IDLE;
      fin_o     = 1'b0;
      fin_err_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      wd_q      <= '0;
      is_addr_q <= 1'b0;
      byte_q    <= '0;
      kind_q    <= XK_PROG;
      rb_sync_q <= 2'b11;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      wd_q      <= wd_d;
      rb_sync_q <= {rb_sync_q[0], rb_ni};
      if (state_q == ST_IDLE && start_i) begin
        is_addr_q <= op_i[1];
        byte_q    <= op_i[1] ? addr_i : cmd_i;
        kind_q    <= kind_d;
      end
    end
  end

  assign strobe      = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign cle_o       = strobe && !is_addr_q;
  assign ale_o       = strobe && is_addr_q;
  assign we_no       = (state_q != ST_PULSE);
  assign dq_oe_o     = strobe;
  assign dq_o        = strobe ? byte_q : 8'h00;
  assign xfer_req_o  = (state_q == ST_XFER);
  assign xfer_kind_o = kind_q;
  assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned WDOG_CYC  = 4096,
  parameter int unsigned RST_CYC   = 8,
  parameter int unsigned NUM_CE    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic              rb_ni,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic [7:0]        dq_o,
  output logic              dq_oe_o,
  output logic [NUM_CE-1:0] ce_no,
  output logic              xfer_req_o,
  output logic [1:0]        xfer_kind_o,
  output logic [2:0]        buf_sel_o
);
  localparam int unsigned CS_W = (NUM_CE > 1) ? $clog2(NUM_CE) : 1;

  logic               busy, fin, fin_err, start, abort, ce_en;
  logic [OP_BITS-1:0] op;
  logic [7:0]         cmd_byte, addr_byte;
  logic [CS_W-1:0]    cs;

  nand_seq_regs #(.RST_CYC(RST_CYC), .CS_W(CS_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .fin_i(fin), .fin_err_i(fin_err),
    .start_o(start), .op_o(op), .abort_o(abort),
    .cmd_o(cmd_byte), .addr_byte_o(addr_byte), .buf_o(buf_sel_o),
    .cs_o(cs), .ce_en_o(ce_en)
  );

  nand_seq_fsm #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC),   .WDOG_CYC(WDOG_CYC)
  ) u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .op_i(op), .abort_i(abort),
    .cmd_i(cmd_byte), .addr_i(addr_byte), .rb_ni,
    .busy_o(busy), .fin_o(fin), .fin_err_o(fin_err),
    .cle_o, .ale_o, .we_no, .dq_o, .dq_oe_o,
    .xfer_req_o, .xfer_kind_o
  );

  for (genvar g = 0; g < NUM_CE; g++) begin : g_ce
    assign ce_no[g] = !(ce_en && (cs == CS_W'(g)));
  end
endmodule

// File: rtl/nand_op_seq_sva.sv
module nand_op_seq_sva #(
  parameter int unsigned NUM_CE = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cle_o,
  input logic              ale_o,
  input logic              we_no,
  input logic [7:0]        dq_o,
  input logic              dq_oe_o,
  input logic [NUM_CE-1:0] ce_no,
  input logic              xfer_req_o
);
  p_strobe_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));

  p_we_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (dq_oe_o && (cle_o || ale_o)));

  p_we_byte_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && $past(!we_no)) |-> $stable(dq_o));

  p_xfer_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |=> !xfer_req_o);

  p_xfer_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> (we_no && !cle_o && !ale_o));

  p_ce_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ce_no) <= 1);
endmodule

bind nand_op_seq nand_op_seq_sva #(.NUM_CE(NUM_CE)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .cle_o(cle_o), .ale_o(ale_o), .we_no(we_no),
  .dq_o(dq_o), .dq_oe_o(dq_oe_o), .ce_no(ce_no), .xfer_req_o(xfer_req_o)
);

// File: tb/nand_op_seq_tb.sv
module nand_op_seq_tb;
  localparam int CLK_NS = 10;
  localparam int S = 2, P = 3, H = 1, WD = 24, RC = 4, NCE = 4;
  localparam int CYC = S + P + H;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 3'd4;
  logic [15:0] wdata = '0, rdata;
  logic rb_n;
  logic cle, ale, we_n, dq_oe, xfer_req;
  logic [7:0] dq;
  logic [NCE-1:0] ce_n;
  logic [1:0] xfer_kind;
  logic [2:0] buf_sel;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  nand_op_seq #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .WDOG_CYC(WD),
                .RST_CYC(RC), .NUM_CE(NCE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rb_ni(rb_n), .cle_o(cle), .ale_o(ale),
    .we_no(we_n), .dq_o(dq), .dq_oe_o(dq_oe), .ce_no(ce_n), .xfer_req_o(xfer_req),
    .xfer_kind_o(xfer_kind), .buf_sel_o(buf_sel));

  // flash ready/busy model
  int m_dly = 1, m_bsy = 3;
  bit m_hang = 0, m_nobusy = 0;
  int m_cnt, m_ph;
  bit m_rel;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_n <= 1'b1; m_ph <= 0; m_cnt <= 0; m_rel <= 1'b0;
    end else begin
      case (m_ph)
        0: if (xfer_req && xfer_kind != 2'd2) begin
          m_rel <= 1'b0;
          if (!m_nobusy) begin m_cnt <= m_dly; m_ph <= 1; end
        end
        1: if (m_cnt == 0) begin rb_n <= 1'b0; m_cnt <= m_bsy; m_ph <= 2; end
           else m_cnt <= m_cnt - 1;
        default: if (!m_hang) begin
          if (m_cnt == 0) begin rb_n <= 1'b1; m_rel <= 1'b1; m_ph <= 0; end
          else m_cnt <= m_cnt - 1;
        end
      endcase
    end
  end

  // pin log: one entry per write-enable pulse {cle, ale, byte}
  logic [9:0] log_q [0:63];
  int nlog = 0;
  logic we_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !we_n && we_prev) begin
      log_q[nlog & 63] = {cle, ale, dq};
      nlog = nlog + 1;
    end
    we_prev = we_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 3'd4;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = rdata; reg_addr = 3'd4; #1;
  endtask

  int n_cle, n_ale, n_we, first_we, n_req, done_at;
  logic [1:0] req_kind;
  logic [2:0] req_buf;
  bit err_at, rel_at;

  task automatic poll(input int limit);
    n_cle = 0; n_ale = 0; n_we = 0; first_we = -1; n_req = 0; done_at = -1;
    err_at = 0; rel_at = 0;
    for (int i = 0; i < limit; i++) begin
      if (cle) n_cle++;
      if (ale) n_ale++;
      if (!we_n) begin n_we++; if (first_we < 0) first_we = i; end
      if (xfer_req) begin n_req++; req_kind = xfer_kind; req_buf = buf_sel; end
      if (rdata[15]) begin done_at = i; err_at = rdata[14]; rel_at = m_rel; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_op(input logic [15:0] opv, input int limit);
    wr(3'd4, opv);
    poll(limit);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int ones;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check(v == 16'h0, "R1 register reset", v, 0);
    end
    check(we_n && !cle && !ale && !xfer_req && ce_n == '1, "R1 pins idle",
          {we_n, cle, ale, xfer_req, ce_n}, {1'b1, 3'b0, 4'hF});

    // R2 command sweep
    for (int c = 0; c < 256; c++) begin
      wr(3'd2, 16'(c));
      run_op(16'h0001, 40);
      check(n_cle == CYC && n_ale == 0 && n_we == P && first_we == S, "R2 command timing",
            {n_cle, n_ale, n_we, first_we}, {CYC, 0, P, S});
      check(log_q[(nlog-1) & 63] == {2'b10, 8'(c)}, "R2 command byte",
            log_q[(nlog-1) & 63], {2'b10, 8'(c)});
      check(done_at == CYC && !err_at, "R4 command done", done_at, CYC);
    end

    // R3 address sweep, high byte must not reach the pins
    for (int a = 0; a < 256; a++) begin
      wr(3'd1, {8'hA5, 8'(a)});
      run_op(16'h0002, 40);
      check(n_ale == CYC && n_cle == 0 && n_we == P && first_we == S, "R3 address timing",
            {n_ale, n_cle, n_we, first_we}, {CYC, 0, P, S});
      check(log_q[(nlog-1) & 63] == {2'b01, 8'(a)}, "R3 address byte",
            log_q[(nlog-1) & 63], {2'b01, 8'(a)});
    end

    // R4 byte latched at start
    wr(3'd2, 16'h0011);
    wr(3'd4, 16'h0001);
    wr(3'd2, 16'h0022);
    poll(40);
    check(log_q[(nlog-1) & 63] == {2'b10, 8'h11}, "R4 byte latched", log_q[(nlog-1) & 63], {2'b10, 8'h11});
    check(done_at > 0, "R4 done seen", done_at, 1);

    // R5 transfer kinds x buffers
    m_dly = 1; m_bsy = 2;
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 8; b++) begin
        wr(3'd0, 16'(b));
        run_op(16'(1 << (k + 2)), 60);
        check(n_req == 1 && req_kind == 2'(k) && req_buf == 3'(b), "R5 request",
              {n_req, req_kind, req_buf}, {1, k, b});
        if (k == 2) check(done_at == 1, "R5 ID completion", done_at, 1);
      end
    end

    // R6 busy sweep
    for (int d = 0; d < 4; d++) begin
      for (int bz = 1; bz < 7; bz++) begin
        m_dly = d; m_bsy = bz;
        run_op((d[0]) ? 16'h0020 : 16'h0008, 60);
        check(done_at > 0 && rel_at && !err_at, "R6 wait for busy release",
              {done_at, rel_at, err_at}, 1);
      end
    end
    m_dly = 0; m_bsy = 2;
    run_op(16'h0004, 60);
    check(done_at > 0 && rel_at && !err_at, "R6 program wait", {rel_at, err_at}, 2);

    // R7 stuck busy and never busy
    m_hang = 1;
    run_op(16'h0004, 80);
    check(done_at == WD + 1 && err_at, "R7 timeout stuck low", {done_at, err_at}, {WD + 1, 1});
    m_hang = 0;
    repeat (12) @(negedge clk);
    m_nobusy = 1;
    run_op(16'h0020, 80);
    check(done_at == WD + 1 && err_at, "R7 timeout never low", {done_at, err_at}, {WD + 1, 1});
    m_nobusy = 0;
    run_op(16'h0001, 40);
    check(done_at == CYC && !err_at, "R7 error cleared by start", {done_at, err_at}, {CYC, 0});

    // R8 write while busy
    m_dly = 0; m_bsy = 10;
    wr(3'd4, 16'h0008);
    wr(3'd4, 16'h0010);
    poll(60);
    check(n_req == 0 && done_at > 0, "R8 busy write ignored", n_req, 0);
    rd(3'd4, v);
    check(v == 16'h8008, "R8 op register kept", v, 16'h8008);
    // R8 non one-hot patterns
    wr(3'd4, 16'h0003);
    poll(6);
    rd(3'd4, v);
    check(v == 16'h8008 && n_cle == 0 && n_ale == 0 && n_req == 0, "R8 multi-bit ignored", v, 16'h8008);
    wr(3'd4, 16'h0000);
    poll(6);
    rd(3'd4, v);
    check(v == 16'h8008 && n_cle == 0 && n_req == 0, "R8 zero ignored", v, 16'h8008);

    // R9 chip enables
    for (int cs = 0; cs < 4; cs++) begin
      for (int en = 0; en < 2; en++) begin
        wr(3'd0, 16'(cs << 5));
        wr(3'd3, 16'(en << 7));
        check(ce_n == (en ? ~(4'b1 << cs) : 4'hF), "R9 chip enable", ce_n,
              en ? ~(4'b1 << cs) : 4'hF);
      end
    end

    // R10 self-clearing reset
    wr(3'd3, 16'h00C0);
    ones = 0;
    for (int i = 0; i <= RC; i++) begin
      rd(3'd3, v);
      if (v[6]) ones++;
      @(negedge clk);
    end
    rd(3'd3, v);
    check(ones == RC && v == 16'h0080, "R10 reset bit self clears", {ones, v}, {RC, 16'h0080});
    m_hang = 1;
    wr(3'd4, 16'h0004);
    repeat (3) @(negedge clk);
    wr(3'd3, 16'h0040);
    repeat (RC + 2) @(negedge clk);
    rd(3'd4, v);
    check(v == 16'h0 && we_n && !cle && !ale, "R10 abort clears", v, 0);
    m_hang = 0;
    repeat (12) @(negedge clk);
    run_op(16'h0001, 40);
    check(done_at == CYC, "R10 usable after abort", done_at, CYC);

    // R11 large page read sequence
    begin
      logic [9:0] exp_seq [0:6];
      int base;
      exp_seq[0] = {2'b10, 8'h00}; exp_seq[1] = {2'b01, 8'h34}; exp_seq[2] = {2'b01, 8'h02};
      exp_seq[3] = {2'b01, 8'h56}; exp_seq[4] = {2'b01, 8'h78}; exp_seq[5] = {2'b01, 8'h01};
      exp_seq[6] = {2'b10, 8'h30};
      base = nlog;
      m_dly = 1; m_bsy = 4;
      for (int i = 0; i < 7; i++) begin
        if (exp_seq[i][9]) begin wr(3'd2, 16'(exp_seq[i][7:0])); run_op(16'h0001, 40); end
        else begin wr(3'd1, 16'(exp_seq[i][7:0])); run_op(16'h0002, 40); end
      end
      run_op(16'h0008, 60);
      for (int i = 0; i < 7; i++)
        check(log_q[(base + i) & 63] == exp_seq[i], "R11 pin order", log_q[(base + i) & 63], exp_seq[i]);
      check(nlog - base == 7 && n_req == 1 && req_kind == 2'd1 && rel_at, "R11 page read",
            {nlog - base, n_req, req_kind}, {7, 1, 1});
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule